// File: doc/BRIEF.md
# External Interrupt Edge-Flag Controller

This block gathers interrupt requests for a small 8-bit microcontroller core. Seven external vectors, numbered 0 to 6, each own a latched edge flag. Every asynchronous input first passes a two-flop synchronizer. Vectors 0 and 1 take a rising edge of a digital input. Vector 3 takes a falling edge of a busy line. Vector 5 takes a falling edge of a memory-busy line, found by inverting the line and detecting a rising edge.

Three vectors are shared by secondary event sources. Each source has its own enable and its own sticky flag. Vector 2 merges two collision events into an active-low line and triggers on its falling edge. Vector 4 merges the rising and falling transitions of a clock-lock status. Vector 6 merges a transfer-done event and a one-second tick into an active-low line, which is inverted and edge-detected. The core supplies per-vector enables and acknowledge pulses, and software clears flags through a small write port. Two timer overflow flags, which the timer acknowledges clear, sit beside the vectors. A pending line per vector is the vector flag gated by its enable.

Top module: `ext_irq_flags`

## Requirements
- R1: `pend[v]` is high exactly when vector flag v is set and `vec_en[v]` is high. A flag still sets and stays latched while its enable is low.
- R2: A rising edge on `dio_hi` sets vector flag 0, and a rising edge on `dio_lo` sets vector flag 1, after synchronization.
- R3: Vectors 2 and 3 trigger on a falling edge of their line. A falling edge of `ce_busy` sets vector flag 3 and a rising edge does not. Vector 2's line is low while any enabled collision sub-flag is set.
- R4: Vector 4 sets when its request rises. The request is high while an enabled lock sub-flag is set. Sub-flag bit 2 sets on a rising edge of `pll_lock`, and sub-flag bit 3 sets on a falling edge of `pll_lock`.
- R5: A falling edge of `eeprom_busy` sets vector flag 5 and a rising edge does not. Vector 6 sets when its active-low line falls, which happens when an enabled transfer or tick sub-flag becomes set.
- R6: Sub-flags set on a rising edge of their source, whether or not the source is enabled. A sub-flag feeds its vector only while its `sub_en` bit is high. The bits are: 0 = `col_a`, 1 = `col_b`, 2 = lock rise, 3 = lock fall, 4 = `xfer_done`, 5 = `sec_tick`.
- R7: A high `vec_ack[v]` clears vector flags 0 through 5. `vec_ack[6]` leaves vector flag 6 unchanged.
- R8: A write with `wr_sel`=0 clears vector flags 2..6 whose bits in `wr_data[5:1]` are zero. A write with `wr_sel`=1 clears sub-flags whose bits in `wr_data[5:0]` are zero. A one bit has no effect.
- R9: `flag_rd` places vector flags 2, 3, 4, 5 and 6 at bits 1, 2, 3, 4 and 5. Bits 0, 6 and 7 read zero. `sub_rd[5:0]` holds the sub-flags and bits 7:6 read zero.
- R10: A high `tmr_ovf[i]` sets `tmr_flag[i]`. A high `tmr_ack[i]` clears it.
- R11: A set event in the same cycle as a clear leaves the flag set.
- R12: A synchronous active-low reset clears all vector, sub and timer flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dio_hi | input | 1 | Async source for vector 0 |
| dio_lo | input | 1 | Async source for vector 1 |
| col_a | input | 1 | Async collision event A (vector 2) |
| col_b | input | 1 | Async collision event B (vector 2) |
| ce_busy | input | 1 | Async busy line for vector 3 |
| pll_lock | input | 1 | Async lock status (vector 4) |
| eeprom_busy | input | 1 | Async busy line for vector 5 |
| xfer_done | input | 1 | Async transfer event (vector 6) |
| sec_tick | input | 1 | Async one-second tick (vector 6) |
| vec_en | input | 7 | Per-vector enables |
| vec_ack | input | 7 | Per-vector acknowledge pulses from the core |
| sub_en | input | 6 | Sub-source enables |
| tmr_ovf | input | 2 | Timer overflow pulses, synchronous |
| tmr_ack | input | 2 | Timer acknowledge pulses |
| wr_en | input | 1 | Flag write strobe |
| wr_sel | input | 1 | 0 = vector flags, 1 = sub-flags |
| wr_data | input | 6 | Write data; zero bits clear |
| pend | output | 7 | Pending request per vector |
| flag_rd | output | 8 | Vector flag register |
| sub_rd | output | 8 | Sub-flag register |
| tmr_flag | output | 2 | Timer overflow flags |

## Verification
On every cycle, the assertions check these rules: vector 6 survives an acknowledge, sub-flags stay sticky between writes, a detected edge always ends up in its flag, an acknowledge clears a timer flag and an auto-clearing vector flag, and reset empties the flags. Only the directed scenarios can show some behaviours. These are the edge polarity of each line, the inverted lines, the gating of shared sources by their sub-enables, the bit layout of the read registers, and whether a one written to a flag bit is harmless.

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int NV = 7,
  parameter int NS = 6,
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dio_hi,
  input  logic          dio_lo,
  input  logic          col_a,
  input  logic          col_b,
  input  logic          ce_busy,
  input  logic          pll_lock,
  input  logic          eeprom_busy,
  input  logic          xfer_done,
  input  logic          sec_tick,
  input  logic [NV-1:0] vec_en,
  input  logic [NV-1:0] vec_ack,
  input  logic [NS-1:0] sub_en,
  input  logic [NT-1:0] tmr_ovf,
  input  logic [NT-1:0] tmr_ack,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [NS-1:0] wr_data,
  output logic [NV-1:0] pend,
  output logic [7:0]    flag_rd,
  output logic [7:0]    sub_rd,
  output logic [NT-1:0] tmr_flag
);
  localparam int NA = 9;
  localparam logic [NV-1:0] FALL = 7'b0001100;
  localparam logic [NV-1:0] INV  = 7'b1100000;
  localparam logic [NV-1:0] AUTO = 7'b0111111;

  logic [NA-1:0] asy, s1, s2, sp;
  logic [NS-1:0] sflag, sset, sact, sclr;
  logic [NV-1:0] vflag, vprev, line, det, vedge, vclr, swclr;

  assign asy = {sec_tick, xfer_done, eeprom_busy, pll_lock, ce_busy,
                col_b, col_a, dio_lo, dio_hi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      sp <= '0;
    end else begin
      s1 <= asy;
      s2 <= s1;
      sp <= s2;
    end
  end

  assign sset[0] = s2[2] & ~sp[2];
  assign sset[1] = s2[3] & ~sp[3];
  assign sset[2] = s2[5] & ~sp[5];
  assign sset[3] = ~s2[5] & sp[5];
  assign sset[4] = s2[7] & ~sp[7];
  assign sset[5] = s2[8] & ~sp[8];
  assign sact    = sflag & sub_en;

  assign line[0] = s2[0];
  assign line[1] = s2[1];
  assign line[2] = ~|sact[1:0];
  assign line[3] = s2[4];
  assign line[4] = |sact[3:2];
  assign line[5] = s2[6];
  assign line[6] = ~|sact[5:4];

  assign det   = line ^ INV;
  assign vedge = (~FALL & det & ~vprev) | (FALL & ~det & vprev);

  assign swclr = (wr_en && !wr_sel) ? {~wr_data[5:1], 2'b00} : '0;
  assign vclr  = (AUTO & vec_ack) | swclr;
  assign sclr  = (wr_en && wr_sel) ? ~wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vprev    <= ~FALL;
      vflag    <= '0;
      sflag    <= '0;
      tmr_flag <= '0;
    end else begin
      vprev    <= det;
      vflag    <= vedge | (vflag & ~vclr);
      sflag    <= sset | (sflag & ~sclr);
      tmr_flag <= tmr_ovf | (tmr_flag & ~tmr_ack);
    end
  end

  assign pend    = vflag & vec_en;
  assign flag_rd = {2'b00, vflag[6:2], 1'b0};
  assign sub_rd  = {2'b00, sflag};

  AST_V6_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vflag[6] && vec_ack[6] && !swclr[6]) |=> vflag[6]); // R7
  AST_V5_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack[5] && !vedge[5]) |=> !vflag[5]); // R7
  AST_SUB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> ((sflag & $past(sflag)) == $past(sflag))); // R8
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|vedge) |=> ((vflag & $past(vedge)) == $past(vedge))); // R11
  AST_TMR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ack[0] && !tmr_ovf[0]) |=> !tmr_flag[0]); // R10
  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (vflag == '0 && sflag == '0 && tmr_flag == '0)); // R12
endmodule

// File: tb/ext_irq_flags_bench.sv
module ext_irq_flags_bench;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic dio_hi = 0, dio_lo = 0, col_a = 0, col_b = 0, ce_busy = 0;
  logic pll_lock = 0, eeprom_busy = 0, xfer_done = 0, sec_tick = 0;
  logic [6:0] vec_en = 0, vec_ack = 0;
  logic [5:0] sub_en = 0, wr_data = 0;
  logic [1:0] tmr_ovf = 0, tmr_ack = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [6:0] pend;
  logic [7:0] flag_rd, sub_rd;
  logic [1:0] tmr_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_irq_flags u_ext_irq_flags (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(int v);
    vec_ack[v] = 1; cyc(1); vec_ack[v] = 0; cyc(1);
  endtask

  task automatic wr(bit sel, logic [5:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1; cyc(1); wr_en = 0; cyc(1);
  endtask

  task automatic t_reset;
    chk("R12 pend", {1'b0, pend}, 8'h00);
    chk("R12 flag_rd", flag_rd, 8'h00);
    chk("R12 sub_rd", sub_rd, 8'h00);
    chk("R12 tmr", {6'd0, tmr_flag}, 8'h00);
  endtask

  task automatic t_vec01;
    vec_en = 7'h01;
    dio_hi = 1; cyc(6);
    chk("R2 vec0", {7'd0, pend[0]}, 8'h01);
    chk("R9 vec0 hidden", flag_rd, 8'h00);
    ack(0);
    chk("R7 vec0 ack", {7'd0, pend[0]}, 8'h00);
    dio_lo = 1; cyc(6);
    chk("R1 masked", {7'd0, pend[1]}, 8'h00);
    vec_en = 7'h03; cyc(1);
    chk("R1 latched", {7'd0, pend[1]}, 8'h01);
    ack(1);
    chk("R7 vec1 ack", {1'b0, pend}, 8'h00);
    dio_hi = 0; dio_lo = 0; cyc(6);
  endtask

  task automatic t_vec3;
    vec_en = 7'h7f;
    ce_busy = 1; cyc(6);
    chk("R3 rise ignored", flag_rd, 8'h00);
    ce_busy = 0; cyc(6);
    chk("R3 fall sets", flag_rd, 8'h04);
    ack(3);
    chk("R7 vec3 ack", flag_rd, 8'h00);
  endtask

  task automatic t_vec5;
    eeprom_busy = 1; cyc(6);
    chk("R5 rise ignored", flag_rd, 8'h00);
    eeprom_busy = 0; cyc(6);
    chk("R5 fall sets", flag_rd, 8'h10);
    wr(0, 6'h3f);
    chk("R8 one no effect", flag_rd, 8'h10);
    wr(0, 6'h2f);
    chk("R8 zero clears", flag_rd, 8'h00);
  endtask

  task automatic t_vec2;
    sub_en = 0;
    col_a = 1; cyc(6);
    chk("R6 sub sets", sub_rd, 8'h01);
    chk("R6 gated off", flag_rd, 8'h00);
    sub_en = 6'h01; cyc(3);
    chk("R3 vec2 via sub", flag_rd, 8'h02);
    ack(2);
    chk("R7 vec2 ack", flag_rd, 8'h00);
    wr(1, 6'h3f);
    chk("R8 sub one", sub_rd, 8'h01);
    wr(1, 6'h3e);
    chk("R8 sub zero", sub_rd, 8'h00);
    col_a = 0; cyc(3);
    chk("R3 release no set", flag_rd, 8'h00);
  endtask

  task automatic t_vec4;
    sub_en = 6'h0c;
    pll_lock = 1; cyc(7);
    chk("R4 rise sub", sub_rd, 8'h04);
    chk("R4 rise vec", flag_rd, 8'h08);
    ack(4); wr(1, 6'h3b);
    chk("R4 cleared", flag_rd | sub_rd, 8'h00);
    pll_lock = 0; cyc(7);
    chk("R4 fall sub", sub_rd, 8'h08);
    chk("R4 fall vec", flag_rd, 8'h08);
    ack(4); wr(1, 6'h37);
  endtask

  task automatic t_vec6;
    sub_en = 6'h20;
    sec_tick = 1; cyc(7);
    chk("R5 vec6 tick", flag_rd, 8'h20);
    chk("R1 pend6", {1'b0, pend}, 8'h40);
    ack(6);
    chk("R7 vec6 holds", flag_rd, 8'h20);
    wr(0, 6'h1f);
    chk("R8 vec6 sw clear", flag_rd, 8'h00);
    wr(1, 6'h1f);
    sec_tick = 0; cyc(3);
    chk("R6 cleanup", flag_rd | sub_rd, 8'h00);
  endtask

  task automatic t_timer;
    tmr_ovf = 2'b01; cyc(1); tmr_ovf = 0; cyc(1);
    chk("R10 set", {6'd0, tmr_flag}, 8'h01);
    tmr_ack = 2'b01; cyc(1); tmr_ack = 0; cyc(1);
    chk("R10 clear", {6'd0, tmr_flag}, 8'h00);
    tmr_ovf = 2'b10; tmr_ack = 2'b10; cyc(1); tmr_ovf = 0; tmr_ack = 0; cyc(1);
    chk("R11 set wins", {6'd0, tmr_flag}, 8'h02);
    tmr_ack = 2'b10; cyc(1); tmr_ack = 0; cyc(1);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_vec01();
    t_vec3();
    t_vec5();
    t_vec2();
    t_vec4();
    t_vec6();
    t_timer();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule